// File: doc/BRIEF.md
# Single-Level Page-Table Address Translator

This block turns a processor virtual address into a physical address by reading one page-table entry from memory. The virtual address splits into a virtual page number in the upper bits and an offset in the lower bits. The offset width follows from the page-size parameter. The entry word sits at the address given by a software-loadable base register plus the virtual page number.

The entry holds a frame number and three control flags. A clear present flag stops the access with a not-present fault. A write to a page whose read-only flag is set stops with a protection fault. A successful write to a page that is not yet marked modified causes a write-back of the entry with the modified flag set. Each request ends with exactly one done pulse, which carries either the physical address or a fault cause.

Top module: `pt_xlate`

## Requirements
- R1: On a successful translation, `pa_o` equals the entry's frame number concatenated with the untouched offset bits of the virtual address. The offset is the low log2(PAGE_BYTES) bits. The frame occupies entry bits [FRM_W+2:3].
- R2: The entry is read from memory address base + VPN, where VPN = va >> log2(PAGE_BYTES). Entry bit 2 is present, bit 1 is modified and bit 0 is read-only.
- R3: If the present bit is 0, the request ends with `fault_o`=1, `cause_o`=2'b01 and `pa_o`=0, and no memory write takes place. This holds whatever the read-only bit and the access type are.
- R4: A write to a present, writable page whose modified bit is 0 writes the entry back to the same address with bit 1 set and all other bits unchanged. The request then ends with no fault.
- R5: A write to a present page whose read-only bit is 1 ends with `fault_o`=1 and `cause_o`=2'b10, and memory is left unchanged.
- R6: A read access never writes the entry, including when the modified bit is 0 or the read-only bit is 1. A successful access reports `cause_o`=2'b00.
- R7: A write to a page whose modified bit is already 1 performs no memory write.
- R8: Each accepted request produces exactly one one-cycle `done_o` pulse. A request strobe raised while a translation is in progress is ignored.
- R9: `base_ld_i` loads `base_i` into the base register only while the unit is idle. A load strobe during a translation has no effect.
- R10: After reset, `done_o`, `fault_o` and `mem_req_o` are 0 and the base register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Translation request strobe |
| va_i | input | VA_W | Virtual address |
| wr_i | input | 1 | Access type: 1 write, 0 read |
| base_ld_i | input | 1 | Base register load strobe |
| base_i | input | PA_W | Value loaded into the base register |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | PA_W | Physical address, valid with done |
| fault_o | output | 1 | Translation refused, valid with done |
| cause_o | output | 2 | 00 none, 01 not present, 10 write to read-only |
| mem_req_o | output | 1 | Memory access request, held until ack |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | PA_W | Memory word address |
| mem_wdata_o | output | 32 | Entry write-back data |
| mem_ack_i | input | 1 | Memory access complete; read data valid |
| mem_rdata_i | input | 32 | Entry read data |

## Verification
The bench checks that a not-present entry wins over a read-only entry. A design that checked the flags in the wrong order would report cause 10 instead of 01. It counts memory write cycles so that it catches a design that writes the entry back on reads, on already-modified pages or on refused writes. Such a design would corrupt the table or waste a memory cycle. It also raises extra request and base-load strobes in the middle of a translation. A design that re-armed on these would give a second done pulse or fetch its next entry from the wrong base.

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [VA_W-1:0] va_i,
  input  logic            wr_i,
  input  logic            base_ld_i,
  input  logic [PA_W-1:0] base_i,
  output logic            done_o,
  output logic [PA_W-1:0] pa_o,
  output logic            fault_o,
  output logic [1:0]      cause_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [PA_W-1:0] mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [31:0]     mem_rdata_i
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int FRM_W = PA_W - OFF_W;
  localparam int B_RO  = 0;
  localparam int B_MOD = 1;
  localparam int B_VLD = 2;
  localparam logic [1:0] C_NONE = 2'b00, C_NP = 2'b01, C_RO = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_UPDATE, S_DONE} st_t;
  st_t st;

  logic [PA_W-1:0]  base_q, ent_addr_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic [31:0]      pte_q;
  logic [FRM_W-1:0] frame;

  assign frame = pte_q[FRM_W+2:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base_q     <= '0;
      ent_addr_q <= '0;
      off_q      <= '0;
      wr_q       <= 1'b0;
      pte_q      <= '0;
      pa_o       <= '0;
      fault_o    <= 1'b0;
      cause_o    <= C_NONE;
    end else begin
      case (st)
        S_IDLE: begin
          if (base_ld_i) base_q <= base_i;
          if (req_i) begin
            ent_addr_q <= base_q + PA_W'(va_i[VA_W-1:OFF_W]);
            off_q      <= va_i[OFF_W-1:0];
            wr_q       <= wr_i;
            st         <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack_i) begin
          pte_q <= mem_rdata_i;
          st    <= S_CHECK;
        end
        S_CHECK: begin
          if (!pte_q[B_VLD]) begin
            fault_o <= 1'b1; cause_o <= C_NP; pa_o <= '0;
            st <= S_DONE;
          end else if (wr_q && pte_q[B_RO]) begin
            fault_o <= 1'b1; cause_o <= C_RO; pa_o <= '0;
            st <= S_DONE;
          end else begin
            fault_o <= 1'b0; cause_o <= C_NONE; pa_o <= {frame, off_q};
            st <= (wr_q && !pte_q[B_MOD]) ? S_UPDATE : S_DONE;
          end
        end
        S_UPDATE: if (mem_ack_i) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done_o      = (st == S_DONE);
  assign mem_req_o   = (st == S_FETCH) || (st == S_UPDATE);
  assign mem_we_o    = (st == S_UPDATE);
  assign mem_addr_o  = ent_addr_q;
  assign mem_wdata_o = pte_q | (32'd1 << B_MOD);

  p_one_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_fault_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fault_o == (cause_o != C_NONE)));
  p_wb_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[B_VLD] && !mem_wdata_o[B_RO] && mem_wdata_o[B_MOD]));
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  p_base_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(base_q));
  p_no_mem_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o);
endmodule

// File: tb/pt_xlate_test.sv
module pt_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, wr_i = 1'b0, base_ld_i = 1'b0;
  logic [31:0] va_i = '0, base_i = '0;
  logic        done_o, fault_o, mem_req_o, mem_we_o;
  logic [31:0] pa_o, mem_addr_o, mem_wdata_o;
  logic [1:0]  cause_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  logic [31:0] mem [64];
  int checks = 0, fails = 0, wr_cnt = 0, done_cnt = 0, cyc = 0;
  logic [31:0] last_addr = '0;

  always #5 clk = ~clk;

  pt_xlate uut (.*);

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (done_o) done_cnt <= done_cnt + 1;
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i   <= 1'b1;
      mem_rdata_i <= mem[mem_addr_o[5:0]];
      last_addr   <= mem_addr_o;
      if (mem_we_o) begin
        mem[mem_addr_o[5:0]] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end
    end else mem_ack_i <= 1'b0;
  end

  function automatic logic [31:0] pte(input logic [19:0] f, input logic v, m, ro);
    return {9'd0, f, v, m, ro};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, input logic wr);
    int t;
    @(negedge clk);
    va_i = va; wr_i = wr; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    t = 0;
    while (!done_o && t < 100) begin @(negedge clk); t++; end
  endtask

  task automatic run_ok(input string tag, input logic [31:0] va, input logic wr,
                        input logic [31:0] exp_pa, input int exp_wr);
    int w0, d0;
    w0 = wr_cnt; d0 = done_cnt;
    xlate(va, wr);
    chk({tag, " done"}, {31'd0, done_o}, 32'd1);
    chk({tag, " pa"}, pa_o, exp_pa);
    chk({tag, " fault"}, {30'd0, fault_o, cause_o}, 32'd0);
    repeat (3) @(negedge clk);
    chk({tag, " writes"}, wr_cnt - w0, exp_wr);
    chk({tag, " pulses"}, done_cnt - d0, 32'd1);
  endtask

  task automatic run_fault(input string tag, input logic [31:0] va, input logic wr,
                           input logic [1:0] exp_c);
    int w0;
    w0 = wr_cnt;
    xlate(va, wr);
    chk({tag, " fault"}, {29'd0, done_o, fault_o, cause_o}, {29'd0, 1'b1, 1'b1, exp_c});
    chk({tag, " pa"}, pa_o, 32'd0);
    repeat (3) @(negedge clk);
    chk({tag, " writes"}, wr_cnt - w0, 32'd0);
  endtask

  task automatic t_reset;
    chk("R10 reset outputs", {29'd0, done_o, fault_o, mem_req_o}, 32'd0);
    xlate(32'h0000_1abc, 1'b0);
    chk("R10 base zero addr", last_addr, 32'd1);
    chk("R10 base zero pa", pa_o, 32'h0007_7abc);
  endtask

  task automatic t_basic;
    @(negedge clk); base_ld_i = 1'b1; base_i = 32'd8;
    @(negedge clk); base_ld_i = 1'b0;
    run_ok("R1 read", 32'h0000_1123, 1'b0, 32'h000a_b123, 0);
    chk("R2 entry addr", last_addr, 32'd9);
    run_ok("R1 r2_ other vpn", 32'h0000_5fff, 1'b0, 32'h0003_3fff, 0);
    chk("R2 entry addr vpn5", last_addr, 32'd13);
  endtask

  task automatic t_faults;
    run_fault("R3 not present read", 32'h0000_2010, 1'b0, 2'b01);
    run_fault("R3 R10 np beats ro", 32'h0000_3010, 1'b1, 2'b01);
    run_fault("R5 write ro", 32'h0000_4444, 1'b1, 2'b10);
    chk("R5 ro entry untouched", mem[12], pte(20'h00444, 1, 0, 1));
  endtask

  task automatic t_writes;
    run_ok("R6 read ro page", 32'h0000_4008, 1'b0, 32'h0044_4008, 0);
    run_ok("R6 read unmod", 32'h0000_6001, 1'b0, 32'h0006_6001, 0);
    chk("R6 entry unchanged", mem[14], pte(20'h00066, 1, 0, 0));
    run_ok("R4 write unmod", 32'h0000_6002, 1'b1, 32'h0006_6002, 1);
    chk("R4 entry modified", mem[14], pte(20'h00066, 1, 1, 0));
    run_ok("R7 write again", 32'h0000_6003, 1'b1, 32'h0006_6003, 0);
  endtask

  task automatic t_busy;
    int d0, t;
    d0 = done_cnt;
    @(negedge clk); va_i = 32'h0000_1000; wr_i = 1'b0; req_i = 1'b1;
    @(negedge clk); va_i = 32'h0000_5000; base_ld_i = 1'b1; base_i = 32'd40;
    @(negedge clk); req_i = 1'b0; base_ld_i = 1'b0;
    t = 0;
    while (!done_o && t < 100) begin @(negedge clk); t++; end
    chk("R8 first pa", pa_o, 32'h000a_b000);
    repeat (10) @(negedge clk);
    chk("R8 one pulse", done_cnt - d0, 32'd1);
    run_ok("R9 base kept", 32'h0000_1004, 1'b0, 32'h000a_b004, 0);
    chk("R9 entry addr", last_addr, 32'd9);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[1]  = pte(20'h00077, 1, 0, 0);
    mem[9]  = pte(20'h000ab, 1, 0, 0);
    mem[10] = pte(20'h00010, 0, 0, 0);
    mem[11] = pte(20'h00011, 0, 0, 1);
    mem[12] = pte(20'h00444, 1, 0, 1);
    mem[13] = pte(20'h00033, 1, 1, 0);
    mem[14] = pte(20'h00066, 1, 0, 0);
    mem[41] = pte(20'h00bad, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_faults;
    t_writes;
    t_busy;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    fails++;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule